// File: doc/BRIEF.md
# Thirty-Two-Bit Integer ALU with Status Flags

This block is a purely combinational integer arithmetic and logic unit for a processor datapath. It takes two operand words and a 4-bit operation code. It returns one result word and four status flags: zero, signed overflow, negative and carry-out. Every arithmetic and logic function is built around a single ripple adder. Each operand can be inverted on its way into the adder and into the bitwise logic, and a carry-in completes the two's complement for subtraction. A final selector picks the bitwise AND, the bitwise OR, the adder sum or the signed less-than bit.

The operand inputs are not a stream. They are plain control and data pins that the surrounding pipeline holds stable for as long as it needs the outputs. The block has no valid/ready handshake, no clock and no stored state. Exceptions on overflow, shifts, multiplication and division are handled elsewhere.

Top module: `alu_core`

## Requirements
- R1: Operation code 4'b0000 gives result = A AND B.
- R2: Operation code 4'b0001 gives result = A OR B.
- R3: Operation code 4'b0010 gives result = low DATA_W bits of A + B.
- R4: Operation code 4'b0110 gives result = low DATA_W bits of A + (NOT B) + 1, which equals A minus B.
- R5: Operation code 4'b1100 gives result = (NOT A) AND (NOT B).
- R6: Operation code 4'b0111 gives result bit 0 = 1 exactly when A < B as signed two's complement values, with all other result bits 0. This holds even when A minus B overflows.
- R7: For a legal code, the zero flag is 1 exactly when every result bit is 0.
- R8: For a legal code, the carry flag is the carry out of the adder's top stage. The adder's inputs are A, inverted when code bit 3 is 1, and B, inverted when code bit 2 is 1, with a carry-in equal to code bit 2.
- R9: For a legal code, the overflow flag is 1 exactly when the two effective adder inputs of R8 share a sign bit and the adder sum's top bit differs from it.
- R10: For a legal code, the negative flag equals the top bit of the result.
- R11: Any code other than the six above gives a result of 0 with all four flags at 0.
- R12: Outputs depend only on the present inputs, with no clock, no latency and no held state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 4 | Operation select: bit 3 inverts A, bit 2 inverts B and sets carry-in, bits 1:0 pick AND/OR/sum/less |
| opnd_a | input | DATA_W | First operand |
| opnd_b | input | DATA_W | Second operand |
| result | output | DATA_W | Selected function value |
| flag_zero | output | 1 | Result is all zeros |
| flag_ovf | output | 1 | Signed overflow of the adder |
| flag_neg | output | 1 | Top bit of the result |
| flag_carry | output | 1 | Carry out of the adder's top stage |

## Verification
The embedded checks are immediate assertions. They assume the inputs are fully known (no X or Z) whenever combinational evaluation settles, because a comparison against an unknown operand would be meaningless. The bench drives every input to a defined value before sampling and changes inputs only between samples. It covers all sixteen operation codes, overflowing and non-overflowing comparisons, and the unused codes with non-zero operands.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } alu_sel_e;

  typedef struct packed {
    logic     legal;
    logic     inv_a;
    logic     inv_b;
    alu_sel_e sel;
  } alu_ctl_t;

  localparam logic [3:0] OP_AND  = 4'b0000;
  localparam logic [3:0] OP_OR   = 4'b0001;
  localparam logic [3:0] OP_ADD  = 4'b0010;
  localparam logic [3:0] OP_SUB  = 4'b0110;
  localparam logic [3:0] OP_LESS = 4'b0111;
  localparam logic [3:0] OP_NOR  = 4'b1100;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [3:0] op_code,
  output alu_ctl_t   ctl
);
  always_comb begin
    ctl.inv_a = op_code[3];
    ctl.inv_b = op_code[2];
    ctl.sel   = alu_sel_e'(op_code[1:0]);
    unique case (op_code)
      OP_AND, OP_OR, OP_ADD, OP_SUB, OP_LESS, OP_NOR: ctl.legal = 1'b1;
      default:                                        ctl.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_operand_prep.sv
module alu_operand_prep #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              inv_a,
  input  logic              inv_b,
  output logic [DATA_W-1:0] eff_a,
  output logic [DATA_W-1:0] eff_b,
  output logic              carry_in
);
  assign eff_a    = inv_a ? ~opnd_a : opnd_a;
  assign eff_b    = inv_b ? ~opnd_b : opnd_b;
  // Inverting B always means a subtraction-style add, so the +1 rides along.
  assign carry_in = inv_b;
endmodule

// File: rtl/alu_ripple_adder.sv
module alu_ripple_adder #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] add_x,
  input  logic [DATA_W-1:0] add_y,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic              cout,
  output logic              ovf
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0] chain;
  assign chain[0] = cin;

  for (genvar i = 0; i < DATA_W; i++) begin : g_stage
    assign sum[i]     = add_x[i] ^ add_y[i] ^ chain[i];
    assign chain[i+1] = (add_x[i] & add_y[i]) | (add_x[i] & chain[i]) | (add_y[i] & chain[i]);
  end

  assign cout = chain[DATA_W];
  // Signed overflow: carry into the top stage disagrees with carry out of it.
  assign ovf  = chain[DATA_W] ^ chain[MSB];
endmodule

// File: rtl/alu_result_mux.sv
module alu_result_mux
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_sel_e          sel,
  input  logic              legal,
  input  logic [DATA_W-1:0] eff_a,
  input  logic [DATA_W-1:0] eff_b,
  input  logic [DATA_W-1:0] sum,
  input  logic              ovf,
  output logic [DATA_W-1:0] result
);
  localparam int MSB = DATA_W - 1;

  logic less_bit;
  assign less_bit = sum[MSB] ^ ovf;

  always_comb begin
    result = '0;
    if (legal) begin
      unique case (sel)
        SEL_AND:  result = eff_a & eff_b;
        SEL_OR:   result = eff_a | eff_b;
        SEL_SUM:  result = sum;
        SEL_LESS: result = {{(DATA_W-1){1'b0}}, less_bit};
        default:  result = '0;
      endcase
    end
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [3:0]        op_code,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] result,
  output logic              flag_zero,
  output logic              flag_ovf,
  output logic              flag_neg,
  output logic              flag_carry
);
  localparam int MSB = DATA_W - 1;

  alu_ctl_t          ctl;
  logic [DATA_W-1:0] eff_a, eff_b, sum;
  logic              cin, cout, ovf;

  alu_decode u_dec (.op_code(op_code), .ctl(ctl));

  alu_operand_prep #(.DATA_W(DATA_W)) u_prep (
    .opnd_a(opnd_a), .opnd_b(opnd_b), .inv_a(ctl.inv_a), .inv_b(ctl.inv_b),
    .eff_a(eff_a), .eff_b(eff_b), .carry_in(cin)
  );

  alu_ripple_adder #(.DATA_W(DATA_W)) u_add (
    .add_x(eff_a), .add_y(eff_b), .cin(cin), .sum(sum), .cout(cout), .ovf(ovf)
  );

  alu_result_mux #(.DATA_W(DATA_W)) u_mux (
    .sel(ctl.sel), .legal(ctl.legal), .eff_a(eff_a), .eff_b(eff_b),
    .sum(sum), .ovf(ovf), .result(result)
  );

  assign flag_zero  = ctl.legal & ~|result;
  assign flag_neg   = ctl.legal & result[MSB];
  assign flag_carry = ctl.legal & cout;
  assign flag_ovf   = ctl.legal & ovf;

  // Embedded checks; inputs are taken to be fully known when evaluated.
  always_comb begin
    if (!$isunknown({op_code, opnd_a, opnd_b})) begin
      if (op_code == OP_ADD)
        a_r3_add_sum: assert ({flag_carry, result} == {1'b0, opnd_a} + {1'b0, opnd_b})
          else $error("R3 add result mismatch");
      if (op_code == OP_SUB)
        a_r4_sub_diff: assert (result == opnd_a - opnd_b)
          else $error("R4 subtract result mismatch");
      if (op_code == OP_LESS)
        a_r6_less_bit: assert (result == {{(DATA_W-1){1'b0}}, ($signed(opnd_a) < $signed(opnd_b))})
          else $error("R6 less-than mismatch");
      if (op_code == OP_ADD && opnd_a[MSB] != opnd_b[MSB])
        a_r9_no_overflow: assert (!flag_ovf)
          else $error("R9 overflow on mixed-sign add");
      if (ctl.legal)
        a_r7_zero_flag: assert (flag_zero == (result == '0))
          else $error("R7 zero flag mismatch");
      if (!ctl.legal)
        a_r11_unused_quiet: assert (result == '0 && !flag_zero && !flag_ovf && !flag_neg && !flag_carry)
          else $error("R11 unused code not quiet");
    end
  end
endmodule

// File: tb/tb_alu_core.sv
module tb_alu_core;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [3:0]   op_code;
  logic [W-1:0] opnd_a, opnd_b, result;
  logic         flag_zero, flag_ovf, flag_neg, flag_carry;

  alu_core #(.DATA_W(W)) dut (
    .op_code(op_code), .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
    .flag_zero(flag_zero), .flag_ovf(flag_ovf), .flag_neg(flag_neg), .flag_carry(flag_carry)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [31:0] rng = 32'h1234_5678;

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h (op %b a %h b %h)",
               req, what, act, exp, op_code, opnd_a, opnd_b);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Behavioural reference: wide integer arithmetic, nothing gate-shaped.
  task automatic model(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                       output logic [W-1:0] r, output logic z, output logic v,
                       output logic n, output logic c);
    logic [W-1:0] xa, xb, s;
    longint unsigned tot;
    bit legal;
    xa = op[3] ? ~a : a;
    xb = op[2] ? ~b : b;
    tot = longint'(xa) + longint'(xb) + longint'(op[2]);
    s = tot[W-1:0];
    legal = 1;
    case (op)
      4'b0000: r = a & b;
      4'b0001: r = a | b;
      4'b0010: r = s;
      4'b0110: r = s;
      4'b0111: r = ($signed(a) < $signed(b)) ? 1 : 0;
      4'b1100: r = ~(a | b);
      default: begin r = '0; legal = 0; end
    endcase
    z = legal && (r == 0);
    n = legal && r[W-1];
    c = legal && tot[W];
    v = legal && (xa[W-1] == xb[W-1]) && (s[W-1] != xa[W-1]);
  endtask

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b0010: return "R3";
      4'b0110: return "R4";
      4'b1100: return "R5";
      4'b0111: return "R6";
      default: return "R11";
    endcase
  endfunction

  task automatic compare_now();
    logic [W-1:0] r;
    logic z, v, n, c;
    bit legal;
    model(op_code, opnd_a, opnd_b, r, z, v, n, c);
    legal = (tag_of(op_code) != "R11");
    check(tag_of(op_code), "result", result, r);
    check(legal ? "R7"  : "R11", "zero",  W'(flag_zero),  W'(z));
    check(legal ? "R8"  : "R11", "carry", W'(flag_carry), W'(c));
    check(legal ? "R9"  : "R11", "ovf",   W'(flag_ovf),   W'(v));
    check(legal ? "R10" : "R11", "neg",   W'(flag_neg),   W'(n));
  endtask

  task automatic apply(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    op_code = op; opnd_a = a; opnd_b = b;
    #2;
    compare_now();
  endtask

  function automatic logic [31:0] next_rng(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : stim
    op_code = 4'b0000; opnd_a = '0; opnd_b = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Idle state: AND of zeros reads zero with zero flag set (R1, R7).
    #2;
    check("R1", "idle result", result, '0);
    check("R7", "idle zero", W'(flag_zero), W'(1));

    apply(4'b0010, 32'h7fff_ffff, 32'h0000_0001); // R9 positive overflow
    apply(4'b0010, 32'hffff_ffff, 32'h0000_0001); // R8 carry, R7 zero
    apply(4'b0010, 32'h8000_0000, 32'h8000_0000); // R9 negative overflow
    apply(4'b0110, 32'h0000_0000, 32'h0000_0001); // R4 borrow, R10 negative
    apply(4'b0110, 32'h8000_0000, 32'h0000_0001); // R4 overflow
    apply(4'b0110, 32'h1234_5678, 32'h1234_5678); // R4 equal, zero
    apply(4'b0111, 32'h8000_0000, 32'h0000_0001); // R6 negative < positive
    apply(4'b0111, 32'h7fff_ffff, 32'hffff_ffff); // R6 overflowing subtract, not less
    apply(4'b0111, 32'h8000_0000, 32'h7fff_ffff); // R6 overflowing subtract, less
    apply(4'b0111, 32'hdead_beef, 32'hdead_beef); // R6 equal
    apply(4'b1100, 32'h0000_0000, 32'h0000_0000); // R5 all ones
    apply(4'b1100, 32'hf0f0_0000, 32'h0000_0f0f);
    apply(4'b0000, 32'hffff_0000, 32'h0ff0_0ff0); // R1
    apply(4'b0001, 32'hffff_0000, 32'h0ff0_0ff0); // R2
    apply(4'b1111, 32'hffff_ffff, 32'hffff_ffff); // R11 unused
    apply(4'b0011, 32'h8000_0000, 32'h8000_0000); // R11 unused

    // R12: two input changes inside one clock half, each seen at once.
    @(negedge clk);
    op_code = 4'b0010; opnd_a = 32'd5; opnd_b = 32'd7;
    #1 check("R12", "same-cycle add", result, 32'd12);
    opnd_b = 32'd9;
    #1 check("R12", "follow change", result, 32'd14);

    for (int i = 0; i < 300; i++) begin
      for (int op = 0; op < 16; op++) begin
        logic [W-1:0] a, b;
        rng = next_rng(rng); a = rng;
        rng = next_rng(rng); b = rng;
        if (i % 5 == 0) b = a;
        if (i % 7 == 0) a = {~b[W-1], a[W-2:0]};
        apply(4'(op), a, b);
      end
    end
    finish_run();
  end
endmodule